// File: doc/BRIEF.md
# Timed Monitor-Wait Controller

This block carries out a user-level request to pause in a low-power state until an event or a time limit. A one-cycle start pulse captures a 32-bit control operand, a 64-bit absolute wake time, a 32-bit OS limit word, the privilege level, a counter-disable control bit and a snapshot of a free-running 64-bit time-stamp counter. The block then checks the operand and the privilege level. It picks the effective deadline as the earlier of the requested wake time and the OS-imposed maximum. It also selects a light or a deep wait state.

While it waits, the block holds `wait_o` high and shows the chosen depth on `deep_o`. The wait ends on a wake event, when the address monitor disarms, or when the counter reaches the deadline. Completion is reported by a one-cycle `done_o` pulse. The pulse carries a flag word, whose carry bit tells whether the OS limit ended the wait, and a fault code. The real power-state entry, instruction decode and interrupt delivery sit outside the block and appear here only as plain signals.

Top module: `tmw_ctrl`

## Requirements
- R1: A start pulse in the idle state latches all operands and the counter value present at that edge. On a valid, armed request whose deadline lies ahead, `wait_o` is high after the second clock edge counted from the start edge. A start pulse arriving while a request is in progress is ignored.
- R2: If any of control operand bits 31:1 is nonzero, the request completes after the second edge with `fault_o` = 1, the carry bit clear, and `wait_o` never asserted.
- R3: If the counter-disable bit is 1 and the privilege level is not 0, the request completes after the second edge with `fault_o` = 2 and no wait. When both fault conditions hold, code 1 is reported. With the counter-disable bit set at privilege 0, the wait proceeds normally.
- R4: During a wait, `deep_o` = 1 when control operand bit 0 is 0, and `deep_o` = 0 when that bit is 1.
- R5: When bit 0 of the OS limit word is 1, a deep request is demoted: `deep_o` stays 0 for the whole wait.
- R6: While waiting, a high level on any bit of `wake_evt_i` ends the wait at the next edge. The bits are: 0 store to the monitored range, 1 NMI, 2 SMI, 3 debug exception, 4 machine check, 5 INIT, 6 external interrupt. The external interrupt acts with no qualification by any interrupt-enable state.
- R7: OS limit bits 31:2, shifted left by two, give a maximum wait in counter ticks; a zero field means no OS maximum. The effective deadline is the smaller of the snapshot plus that limit and the requested wake time, with a tie going to the requested time. The wait ends at the edge where the sampled counter first equals or exceeds the effective deadline.
- R8: If `mon_armed_i` is low at the checking edge, the request completes without waiting. If it falls during a wait, the wait ends at the next edge.
- R9: `done_o` is high for exactly one cycle per request, and is never high together with `wait_o`. `flags_o` and `fault_o` are zero whenever `done_o` is low.
- R10: `flags_o` bit 0 is the carry. It is 1 only when the OS limit was the chosen deadline and the counter has reached it at exit. `flags_o` bits 5:1 (parity, auxiliary, zero, sign, overflow) are always 0.
- R11: If the counter already equals or exceeds the effective deadline at the checking edge, the request completes after the second edge with no wait.
- R12: After reset, `wait_o`, `deep_o`, `done_o`, `flags_o` and `fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request pulse |
| ctrl_op_i | input | 32 | Control operand; bit 0 selects light (1) or deep (0) |
| wake_time_i | input | 64 | Absolute requested wake time in counter ticks |
| os_limit_i | input | 32 | OS limit word: bits 31:2 maximum wait / 4, bit 0 demote deep requests |
| tsc_i | input | 64 | Free-running time-stamp counter |
| cpl_i | input | 2 | Current privilege level |
| tsc_disable_i | input | 1 | Counter-disable control bit |
| mon_armed_i | input | 1 | Address monitor armed |
| wake_evt_i | input | 7 | Wake events (see R6) |
| wait_o | output | 1 | Wait state active |
| deep_o | output | 1 | Deep wait state selected (valid with `wait_o`) |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 6 | Result flags; bit 0 carry, bits 5:1 zero |
| fault_o | output | 2 | 0 none, 1 reserved operand bits, 2 privilege |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that the counter only moves forward between a start and its completion. They also assume that wake events and the monitor state are levels sampled at the clock edge. The stimulus drives every input on the falling edge, starts a new request only after the previous `done_o` pulse has passed, and advances the counter by exactly one per cycle. It never asks for a deadline that would wrap the 64-bit counter. Wake events are held for a single cycle and are raised only while `wait_o` is high.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } tmw_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_RSVD = 2'd1,
    FLT_PRIV = 2'd2
  } tmw_fault_e;

  localparam int FLAG_W   = 6;
  localparam int FLAG_CF  = 0;
endpackage

// File: rtl/tmw_opcheck.sv
module tmw_opcheck
  import tmw_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int CPL_W  = 2
) (
  input  logic [CTRL_W-1:0] op_i,
  input  logic [CPL_W-1:0]  cpl_i,
  input  logic              tsd_i,
  output tmw_fault_e        fault_o,
  output logic              light_o
);
  logic rsvd_set;
  logic priv_bad;

  assign rsvd_set = |op_i[CTRL_W-1:1];
  assign priv_bad = tsd_i && (cpl_i != '0);
  assign light_o  = op_i[0];

  always_comb begin
    if (rsvd_set)      fault_o = FLT_RSVD;
    else if (priv_bad) fault_o = FLT_PRIV;
    else               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/tmw_deadline_sel.sv
module tmw_deadline_sel #(
  parameter int TSC_W     = 64,
  parameter int LIM_W     = 32,
  parameter int LIM_SHIFT = 2
) (
  input  logic [TSC_W-1:0] snap_i,
  input  logic [TSC_W-1:0] wake_time_i,
  input  logic [LIM_W-1:0] os_limit_i,
  output logic [TSC_W-1:0] deadline_o,
  output logic             use_os_o
);
  localparam logic [LIM_W-1:0] LOW_MASK = LIM_W'((1 << LIM_SHIFT) - 1);

  logic [LIM_W-1:0] os_ticks;
  logic [TSC_W:0]   os_sum;

  assign os_ticks   = os_limit_i & ~LOW_MASK;
  assign os_sum     = {1'b0, snap_i} + (TSC_W+1)'(os_ticks);
  assign use_os_o   = (os_ticks != '0) && (os_sum < {1'b0, wake_time_i});
  assign deadline_o = use_os_o ? os_sum[TSC_W-1:0] : wake_time_i;
endmodule

// File: rtl/tmw_wake_detect.sv
module tmw_wake_detect #(
  parameter int NUM_WAKE = 7,
  parameter int TSC_W    = 64
) (
  input  logic [NUM_WAKE-1:0] evt_i,
  input  logic                armed_i,
  input  logic [TSC_W-1:0]    tsc_i,
  input  logic [TSC_W-1:0]    deadline_i,
  output logic                evt_any_o,
  output logic                disarm_o,
  output logic                timer_hit_o
);
  logic [NUM_WAKE:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_or
    assign chain[g+1] = chain[g] | evt_i[g];
  end

  assign evt_any_o   = chain[NUM_WAKE];
  assign disarm_o    = !armed_i;
  assign timer_hit_o = (tsc_i >= deadline_i);
endmodule

// File: rtl/tmw_ctrl.sv
module tmw_ctrl
  import tmw_pkg::*;
#(
  parameter int CTRL_W    = 32,
  parameter int TSC_W     = 64,
  parameter int LIM_W     = 32,
  parameter int LIM_SHIFT = 2,
  parameter int CPL_W     = 2,
  parameter int NUM_WAKE  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CTRL_W-1:0]   ctrl_op_i,
  input  logic [TSC_W-1:0]    wake_time_i,
  input  logic [LIM_W-1:0]    os_limit_i,
  input  logic [TSC_W-1:0]    tsc_i,
  input  logic [CPL_W-1:0]    cpl_i,
  input  logic                tsc_disable_i,
  input  logic                mon_armed_i,
  input  logic [NUM_WAKE-1:0] wake_evt_i,
  output logic                wait_o,
  output logic                deep_o,
  output logic                done_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [1:0]          fault_o
);
  tmw_state_e        state_q;
  logic [CTRL_W-1:0] op_q;
  logic [TSC_W-1:0]  wake_q;
  logic [LIM_W-1:0]  lim_q;
  logic [TSC_W-1:0]  snap_q;
  logic [CPL_W-1:0]  cpl_q;
  logic              tsd_q;

  tmw_fault_e        chk_fault;
  logic              req_light;
  logic [TSC_W-1:0]  deadline;
  logic              use_os;
  logic              evt_any;
  logic              disarm;
  logic              timer_hit;
  logic              go_deep;

  tmw_opcheck #(.CTRL_W(CTRL_W), .CPL_W(CPL_W)) opcheck_i (
    .op_i    (op_q),
    .cpl_i   (cpl_q),
    .tsd_i   (tsd_q),
    .fault_o (chk_fault),
    .light_o (req_light)
  );

  tmw_deadline_sel #(.TSC_W(TSC_W), .LIM_W(LIM_W), .LIM_SHIFT(LIM_SHIFT)) dsel_i (
    .snap_i      (snap_q),
    .wake_time_i (wake_q),
    .os_limit_i  (lim_q),
    .deadline_o  (deadline),
    .use_os_o    (use_os)
  );

  tmw_wake_detect #(.NUM_WAKE(NUM_WAKE), .TSC_W(TSC_W)) wake_i (
    .evt_i       (wake_evt_i),
    .armed_i     (mon_armed_i),
    .tsc_i       (tsc_i),
    .deadline_i  (deadline),
    .evt_any_o   (evt_any),
    .disarm_o    (disarm),
    .timer_hit_o (timer_hit)
  );

  // deep state only when requested and not demoted by the OS word
  assign go_deep = !req_light && !lim_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      wake_q  <= '0;
      lim_q   <= '0;
      snap_q  <= '0;
      cpl_q   <= '0;
      tsd_q   <= 1'b0;
      wait_o  <= 1'b0;
      deep_o  <= 1'b0;
      done_o  <= 1'b0;
      flags_o <= '0;
      fault_o <= FLT_NONE;
    end else begin
      done_o  <= 1'b0;
      flags_o <= '0;
      fault_o <= FLT_NONE;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q    <= ctrl_op_i;
            wake_q  <= wake_time_i;
            lim_q   <= os_limit_i;
            snap_q  <= tsc_i;
            cpl_q   <= cpl_i;
            tsd_q   <= tsc_disable_i;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            done_o  <= 1'b1;
            fault_o <= chk_fault;
            state_q <= ST_DONE;
          end else if (disarm || timer_hit) begin
            done_o           <= 1'b1;
            flags_o[FLAG_CF] <= use_os && timer_hit;
            state_q          <= ST_DONE;
          end else begin
            wait_o  <= 1'b1;
            deep_o  <= go_deep;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (evt_any || disarm || timer_hit) begin
            wait_o           <= 1'b0;
            deep_o           <= 1'b0;
            done_o           <= 1'b1;
            flags_o[FLAG_CF] <= use_os && timer_hit;
            state_q          <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tmw_ctrl_chk.sv
module tmw_ctrl_chk #(
  parameter int NUM_WAKE = 7,
  parameter int FLAG_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_WAKE-1:0] wake_evt_i,
  input logic                mon_armed_i,
  input logic                wait_o,
  input logic                deep_o,
  input logic                done_o,
  input logic [FLAG_W-1:0]   flags_o,
  input logic [1:0]          fault_o
);
  p_done_wait_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done_o && wait_o));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (flags_o == '0) && (fault_o == 2'd0));

  p_fault_no_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && fault_o != 2'd0) |-> !$past(wait_o) && !flags_o[0]);

  p_event_ends_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (wait_o && (|wake_evt_i)) |=> (done_o && !wait_o));

  p_disarm_ends_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (wait_o && !mon_armed_i) |=> done_o);

  p_deep_only_waiting_r4: assert property (@(posedge clk) disable iff (rst)
    deep_o |-> wait_o);
endmodule

bind tmw_ctrl tmw_ctrl_chk #(.NUM_WAKE(NUM_WAKE), .FLAG_W(tmw_pkg::FLAG_W)) chk_i (.*);

// File: tb/tmw_ctrl_tb_top.sv
module tmw_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] op;
  logic [63:0] wtime;
  logic [31:0] lim;
  logic [63:0] tsc = 64'd1000;
  logic [1:0]  cpl;
  logic        tsd;
  logic        armed;
  logic [6:0]  evt;
  logic        wait_s, deep_s, done_s;
  logic [5:0]  flags_s;
  logic [1:0]  fault_s;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tsc <= tsc + 64'd1;

  tmw_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start), .ctrl_op_i(op), .wake_time_i(wtime),
    .os_limit_i(lim), .tsc_i(tsc), .cpl_i(cpl), .tsc_disable_i(tsd),
    .mon_armed_i(armed), .wake_evt_i(evt), .wait_o(wait_s), .deep_o(deep_s),
    .done_o(done_s), .flags_o(flags_s), .fault_o(fault_s)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive a request; returns the counter value the design captures
  task automatic launch(input logic [31:0] op_v, input logic [63:0] off,
                        input logic [31:0] lim_v, input logic [1:0] cpl_v,
                        input logic tsd_v, output logic [63:0] snap);
    @(negedge clk);
    op = op_v; lim = lim_v; cpl = cpl_v; tsd = tsd_v;
    wtime = tsc + off; snap = tsc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_s && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R12", "wait", wait_s, 0);
    chk("R12", "deep", deep_s, 0);
    chk("R12", "done", done_s, 0);
    chk("R12", "flags", flags_s, 0);
    chk("R12", "fault", fault_s, 0);
  endtask

  task automatic t_state(input logic [31:0] op_v, input logic [31:0] lim_v,
                         input logic exp_deep, input string req);
    logic [63:0] s;
    int c;
    launch(op_v, 64'd50, lim_v, 2'd0, 1'b0, s);
    @(negedge clk);
    chk("R1", "wait entered", wait_s, 1);
    chk(req, "deep select", deep_s, exp_deep);
    wait_done(c);
    chk("R7", "end time", tsc - 64'd1, s + 64'd50);
    chk("R10", "flags", flags_s, 0);
    @(negedge clk);
    chk("R9", "done dropped", done_s, 0);
  endtask

  task automatic t_timer(input logic [31:0] lim_v, input logic [63:0] off,
                         input logic [63:0] end_off, input logic cf, input string req);
    logic [63:0] s;
    int c;
    launch(32'd1, off, lim_v, 2'd0, 1'b0, s);
    wait_done(c);
    chk(req, "end time", tsc - 64'd1, s + end_off);
    chk("R10", "carry", flags_s[0], cf);
    chk("R10", "upper flags", flags_s[5:1], 0);
    @(negedge clk);
  endtask

  task automatic t_events();
    logic [63:0] s;
    for (int k = 0; k < 7; k++) begin
      launch(32'd0, 64'd1000000, 32'd0, 2'd0, 1'b0, s);
      repeat (3) @(negedge clk);
      evt[k] = 1'b1;
      @(negedge clk);
      evt = '0;
      chk("R6", $sformatf("event %0d done", k), done_s, 1);
      chk("R6", $sformatf("event %0d wait", k), wait_s, 0);
      chk("R10", "carry after event", flags_s[0], 0);
      @(negedge clk);
    end
  endtask

  task automatic t_disarm();
    logic [63:0] s;
    launch(32'd0, 64'd1000000, 32'd0, 2'd0, 1'b0, s);
    repeat (2) @(negedge clk);
    armed = 1'b0;
    @(negedge clk);
    chk("R8", "disarm ends wait", done_s, 1);
    chk("R8", "wait low", wait_s, 0);
    armed = 1'b1;
    @(negedge clk);
    armed = 1'b0;
    launch(32'd0, 64'd50, 32'd0, 2'd0, 1'b0, s);
    @(negedge clk);
    chk("R8", "unarmed entry done", done_s, 1);
    chk("R8", "unarmed entry wait", wait_s, 0);
    armed = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_past();
    logic [63:0] s;
    launch(32'd0, 64'd0, 32'd20, 2'd0, 1'b0, s);
    @(negedge clk);
    chk("R11", "done immediate", done_s, 1);
    chk("R11", "no wait", wait_s, 0);
    chk("R11", "carry", flags_s[0], 0);
    @(negedge clk);
  endtask

  task automatic t_fault(input logic [31:0] op_v, input logic [1:0] cpl_v,
                         input logic tsd_v, input logic [1:0] exp_f, input string req);
    logic [63:0] s;
    logic seen = 1'b0;
    launch(op_v, 64'd50, 32'd0, cpl_v, tsd_v, s);
    seen = seen | wait_s;
    @(negedge clk);
    seen = seen | wait_s;
    chk(req, "fault done", done_s, 1);
    chk(req, "fault code", fault_s, exp_f);
    chk(req, "fault carry", flags_s[0], 0);
    @(negedge clk);
    seen = seen | wait_s;
    chk(req, "never waited", seen, 0);
  endtask

  task automatic t_priv_ok_and_busy();
    logic [63:0] s;
    launch(32'd0, 64'd1000000, 32'd0, 2'd0, 1'b1, s);
    @(negedge clk);
    chk("R3", "tsd at level 0 waits", wait_s, 1);
    start = 1'b1; op = 32'h4;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "busy start ignored", wait_s, 1);
    evt[0] = 1'b1;
    @(negedge clk);
    evt = '0;
    chk("R1", "busy start no fault", fault_s, 0);
    chk("R1", "busy start done", done_s, 1);
    @(negedge clk);
    chk("R1", "no second request", done_s | wait_s, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = '0; wtime = '0; lim = '0;
    cpl = '0; tsd = 1'b0; armed = 1'b1; evt = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_state(32'd0, 32'd0, 1'b1, "R4");
    t_state(32'd1, 32'd0, 1'b0, "R4");
    t_state(32'd0, 32'd1, 1'b0, "R5");
    t_timer(32'd20,  64'd100, 64'd20, 1'b1, "R7 os limit");
    t_timer(32'd40,  64'd15,  64'd15, 1'b0, "R7 instr first");
    t_timer(32'd20,  64'd20,  64'd20, 1'b0, "R7 tie");
    t_timer(32'd3,   64'd30,  64'd30, 1'b0, "R7 zero field");
    t_timer(32'd37,  64'd500, 64'd36, 1'b1, "R7 low bits masked");
    t_events();
    t_disarm();
    t_past();
    t_fault(32'h2,         2'd0, 1'b0, 2'd1, "R2");
    t_fault(32'h8000_0001, 2'd0, 1'b0, 2'd1, "R2");
    t_fault(32'h0,         2'd3, 1'b1, 2'd2, "R3");
    t_fault(32'h1,         2'd1, 1'b1, 2'd2, "R3");
    t_fault(32'h2,         2'd3, 1'b1, 2'd1, "R3 precedence");
    t_priv_ok_and_busy();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule